// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block is the control unit of a microprogrammed datapath. A next-address sequencer holds the micro program counter (the fetch address). That address reads a 1024-word microprogram ROM that the block contains. The fetched 32-bit microword is loaded into a pipeline register. Its datapath fields leave the block as registered outputs, so they change on the same clock edge as the datapath's own registers.

The pipeline register lets the fetch of one microword overlap the execution of the previous one. The sequencer therefore steers the fetch address with the next-address operation of the word now being executed. A branch, call or return takes effect one cycle late, and the word fetched just after a control word always executes.

The next-address logic selects one of four operations:
- continue: increment the address.
- conditional jump: go to the literal target when `cond_i` is high.
- call: go to the target and push the return address.
- return: pop the return address.

The return stack holds four entries.

The sequencing rule is one process for the fetch-address register, keyed on an enumerated operation with four named cases. Those cases, taken from microword bits [31:30], are:

| Code | Case | Next fetch address |
|------|------|--------------------|
| 00 | `OP_CONT` | current + 1 |
| 01 | `OP_JMP` | target if `cond_i` is high, else current + 1 |
| 10 | `OP_CALL` | target |
| 11 | `OP_RET` | popped address |

A separate process registers the outputs.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset does three things: it sets the fetch address to 0, loads the pipeline register with a no-operation word, and empties the return stack. The no-operation word has op 00 and all fields zero, so `instr_o`, `a_sel_o`, `b_sel_o` and `lit_o` read 0 at the next edge.
- R2: The control outputs always show the fields of the word that was fetched one cycle earlier. The word fetched right after a control word is always executed.
- R3: Op 00 (continue) in the pipeline makes the next fetch address the current fetch address plus 1, modulo 1024.
- R4: Op 01 (conditional jump) in the pipeline makes the next fetch address the target field when `cond_i` is high at that edge. Otherwise the next fetch address is the current fetch address plus 1.
- R5: Op 10 (call) in the pipeline makes the next fetch address the target field. It also pushes the current fetch address plus 1 onto the return stack.
- R6: Op 11 (return) in the pipeline makes the next fetch address the most recently pushed address that has not yet been popped, and removes that entry.
- R7: A call made while the four-entry stack is full discards the oldest entry. The four newest entries are kept.
- R8: A return made while the stack is empty yields address 0 and leaves the stack empty.
- R9: The microword layout and the ROM word held at address `a` (with `o = a[4:0]`) are:

| Bits | Field | Content at address `a` |
|------|-------|------------------------|
| [31:30] | op | 01 for `o` in 16..23, 10 for `o` = 24, 11 for `o` = 28, 00 otherwise |
| [29:20] | target | `{a[9:5]+1 mod 32, a[0], 2'b11, a[1], 1'b0}` |
| [19:11] | instruction | `a[8:0]` |
| [10:7] | A address | `{a[9], a[2:0]}` |
| [6:3] | B address | `a[7:4]` |
| [2:0] | literal | `a[2:0] ^ 3'b101` |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 1 | Branch condition for op 01 |
| instr_o | output | 9 | Registered datapath instruction code |
| a_sel_o | output | 4 | Registered register-file A address |
| b_sel_o | output | 4 | Registered register-file B address |
| lit_o | output | 3 | Registered direct-data literal |

## Verification
The assertions take for granted that `cond_i` and `rst` are stable around each rising clock edge. They also assume that reset is held for at least one edge before any sequencing is judged, so no check reaches back across a reset. The stimulus changes `cond_i` and `rst` only at falling edges. It begins every scenario with a two-cycle reset, so each property starts from an empty stack and a no-operation pipeline. The conditional input is then held low, held high, switched once, or driven from a pseudo-random register. These patterns lead the fixed ROM program into deep call nesting, stack overflow, unwinding, and returns made with an empty stack.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W  = 10;
    localparam int WORD_W  = 32;
    localparam int INSTR_W = 9;
    localparam int SEL_W   = 4;
    localparam int LIT_W   = WORD_W - 2 - ADDR_W - INSTR_W - 2 * SEL_W;
    localparam int BLK_W   = 5;

    typedef enum logic [1:0] {
        OP_CONT = 2'b00,
        OP_JMP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } nxt_op_e;

    typedef struct packed {
        nxt_op_e              op;
        logic [ADDR_W-1:0]    target;
        logic [INSTR_W-1:0]   instr;
        logic [SEL_W-1:0]     a_sel;
        logic [SEL_W-1:0]     b_sel;
        logic [LIT_W-1:0]     lit;
    } uword_t;

    localparam uword_t NOP_WORD = '{op: OP_CONT, default: '0};

    // Fixed microprogram: blocks of 32 words, one call and one return per block.
    function automatic uword_t rom_word(input logic [ADDR_W-1:0] a);
        uword_t w;
        logic [BLK_W-1:0] off;
        off = a[BLK_W-1:0];
        w.op = OP_CONT;
        if (off[4:3] == 2'b10) begin
            w.op = OP_JMP;
        end else if (off == 5'd24) begin
            w.op = OP_CALL;
        end else if (off == 5'd28) begin
            w.op = OP_RET;
        end
        w.target = {a[ADDR_W-1:BLK_W] + 5'd1, a[0], 2'b11, a[1], 1'b0};
        w.instr  = a[INSTR_W-1:0];
        w.a_sel  = {a[ADDR_W-1], a[2:0]};
        w.b_sel  = a[7:4];
        w.lit    = a[2:0] ^ 3'b101;
        return w;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);

    localparam int DEPTH = 2 ** AW;

    uword_t mem [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_rom
            assign mem[gi] = rom_word(ADDR_W'(gi));
        end
    endgenerate

    assign word = mem[addr];

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] pop_val
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [AW-1:0]    mem_q [DEPTH];
    logic [PTR_W-1:0] top_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] top_inc;
    logic [PTR_W-1:0] top_dec;
    logic             empty;

    assign top_inc = (top_q == PTR_W'(DEPTH - 1)) ? '0 : top_q + PTR_W'(1);
    assign top_dec = (top_q == '0) ? PTR_W'(DEPTH - 1) : top_q - PTR_W'(1);
    assign empty   = (cnt_q == '0);

    // Circular store: a push on a full stack lands on the oldest slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            top_q        <= top_inc;
            mem_q[top_inc] <= push_val;
            if (cnt_q != FULL) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (pop && !empty) begin
            top_q <= top_dec;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign pop_val = empty ? '0 : mem_q[top_q];

    assert_push_visible_R5: assert property (@(posedge clk) disable iff (rst)
        push |=> (pop_val == $past(push_val)));

    assert_full_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        (push && cnt_q == FULL) |=> (cnt_q == FULL));

    assert_empty_pop_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> (empty && pop_val == '0));

    assert_one_action_R6: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  nxt_op_e       op,
    input  logic          cond,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] ret_addr,
    output logic [AW-1:0] npc,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] push_val
);

    logic [AW-1:0] pc_inc;

    assign pc_inc   = pc + AW'(1);
    assign push_val = pc_inc;

    always_comb begin
        npc  = pc_inc;
        push = 1'b0;
        pop  = 1'b0;
        unique case (op)
            OP_CONT: npc = pc_inc;
            OP_JMP:  npc = cond ? target : pc_inc;
            OP_CALL: begin
                npc  = target;
                push = 1'b1;
            end
            OP_RET: begin
                npc = ret_addr;
                pop = 1'b1;
            end
            default: npc = pc_inc;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int STK_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cond_i,
    output logic [INSTR_W-1:0] instr_o,
    output logic [SEL_W-1:0]   a_sel_o,
    output logic [SEL_W-1:0]   b_sel_o,
    output logic [LIT_W-1:0]   lit_o
);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;
    uword_t        pipe_q;
    uword_t        fetch_word;
    logic          stk_push;
    logic          stk_pop;
    logic [AW-1:0] stk_push_val;
    logic [AW-1:0] stk_top;
    logic [AW-1:0] pc_plus1;

    assign pc_plus1 = pc_q + AW'(1);

    useq_rom #(.AW(AW)) rom_i (
        .addr (pc_q),
        .word (fetch_word)
    );

    useq_next #(.AW(AW)) next_i (
        .op       (pipe_q.op),
        .cond     (cond_i),
        .pc       (pc_q),
        .target   (pipe_q.target),
        .ret_addr (stk_top),
        .npc      (pc_d),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (stk_push_val)
    );

    useq_stack #(.DEPTH(STK_DEPTH), .AW(AW)) stack_i (
        .clk      (clk),
        .rst      (rst),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (stk_push_val),
        .pop_val  (stk_top)
    );

    // Sequencer state: the fetch address.
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Pipeline register: the word being executed.
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= NOP_WORD;
        end else begin
            pipe_q <= fetch_word;
        end
    end

    assign instr_o = pipe_q.instr;
    assign a_sel_o = pipe_q.a_sel;
    assign b_sel_o = pipe_q.b_sel;
    assign lit_o   = pipe_q.lit;

    assert_pipe_follows_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pipe_q == $past(fetch_word)));

    assert_continue_R3: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.op == OP_CONT) |=> (pc_q == $past(pc_plus1)));

    assert_jump_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.op == OP_JMP && cond_i) |=> (pc_q == $past(pipe_q.target)));

    assert_jump_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.op == OP_JMP && !cond_i) |=> (pc_q == $past(pc_plus1)));

    assert_call_target_R5: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.op == OP_CALL) |=> (pc_q == $past(pipe_q.target)
                                    && stk_top == $past(pc_plus1)));

    assert_return_R6: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.op == OP_RET) |=> (pc_q == $past(stk_top)));

endmodule

// File: tb/useq_sequencer_tb_top.sv
module useq_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cond_i = 1'b0;
    logic [8:0] instr_o;
    logic [3:0] a_sel_o;
    logic [3:0] b_sel_o;
    logic [2:0] lit_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    int unsigned m_pc;
    int unsigned m_pa;
    bit          m_nop;
    logic [9:0]  m_stk[$];
    string       tag_pc;
    string       tag_pipe;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    useq_sequencer dut_i (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cond_i),
        .instr_o (instr_o),
        .a_sel_o (a_sel_o),
        .b_sel_o (b_sel_o),
        .lit_o   (lit_o)
    );

    // Program per R9
    function automatic int op_of(input int unsigned a);
        int unsigned o = a % 32;
        if (o >= 16 && o < 24) return 1;
        if (o == 24) return 2;
        if (o == 28) return 3;
        return 0;
    endfunction

    function automatic int unsigned tgt_of(input int unsigned a);
        int unsigned blk = ((a / 32) + 1) % 32;
        return blk * 32 + (a % 2) * 16 + 12 + ((a / 2) % 2) * 2;
    endfunction

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        int unsigned ei, ea, eb, el;
        if (m_nop) begin
            ei = 0; ea = 0; eb = 0; el = 0;
        end else begin
            ei = m_pa % 512;
            ea = ((m_pa / 512) % 2) * 8 + (m_pa % 8);
            eb = (m_pa / 16) % 16;
            el = (m_pa % 8) ^ 5;
        end
        check(tag_pipe, "instr", instr_o, ei);
        check(tag_pipe, "a_sel", a_sel_o, ea);
        check(tag_pipe, "b_sel", b_sel_o, eb);
        check(tag_pipe, "lit",   lit_o,   el);
    endtask

    task automatic model_edge(input bit c, input bit r);
        int          op;
        int unsigned nxt;
        int unsigned npc;
        string       t;
        if (r) begin
            m_pc = 0;
            m_nop = 1'b1;
            m_stk.delete();
            tag_pipe = "R1";
            tag_pc = "R9";
            return;
        end
        op  = m_nop ? 0 : op_of(m_pa);
        nxt = (m_pc + 1) % 1024;
        case (op)
            0: begin t = "R3"; npc = nxt; end
            1: begin t = "R4"; npc = c ? tgt_of(m_pa) : nxt; end
            2: begin
                t = (m_stk.size() == 4) ? "R7" : "R5";
                m_stk.push_back(10'(nxt));
                if (m_stk.size() > 4) void'(m_stk.pop_front());
                npc = tgt_of(m_pa);
            end
            default: begin
                if (m_stk.size() == 0) begin
                    t = "R8"; npc = 0;
                end else begin
                    t = "R6"; npc = m_stk.pop_back();
                end
            end
        endcase
        tag_pipe = tag_pc;
        tag_pc = t;
        m_pa = m_pc;
        m_nop = 1'b0;
        m_pc = npc;
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input bit c, input bit r);
        cond_i = c;
        rst = r;
        @(posedge clk);
        #1;
        model_edge(c, r);
        @(negedge clk);
        if (!r) compare_outputs();
    endtask

    task automatic apply_reset();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
    endtask

    task automatic t_reset_state();
        apply_reset();
        // R1: no-operation word in pipeline after reset
        check("R1", "instr after reset", instr_o, 0);
        check("R1", "lit after reset",   lit_o,   0);
        step(1'b0, 1'b0);
        // R2/R9: first edge after release exposes word 0
        check("R2", "lit of word 0", lit_o, 5);
        check("R9", "b_sel of word 0", b_sel_o, 0);
        step(1'b0, 1'b0);
        check("R3", "instr of word 1", instr_o, 1);
    endtask

    task automatic t_cond_low_nesting();
        apply_reset();
        for (int i = 0; i < 400; i++) step(1'b0, 1'b0);
    endtask

    task automatic t_cond_high_empty_return();
        apply_reset();
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
    endtask

    task automatic t_switch_unwind();
        apply_reset();
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 400; i++) step(1'b1, 1'b0);
    endtask

    task automatic t_random_cond();
        apply_reset();
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] ^ lfsr[5], 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_cond_low_nesting();
        t_cond_high_empty_return();
        t_switch_unwind();
        t_random_cond();
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule